// File: doc/BRIEF.md
# Masked Vector Leading Zero Counter

This block takes a 512-bit vector made of eight 64-bit lanes and finds, for every lane at the same time, how many zero bits sit above the highest set bit. Each count is placed right-aligned in the matching 64-bit lane of a registered result, and every bit above the count is zero.

An 8-bit lane mask controls which lanes receive their count. A mode input sets what happens to the other lanes. In zeroing mode they become zero. In merge mode they take the matching lane of a pass-through vector.

A request is presented with `in_valid` high. The result and `out_valid` appear on the next clock edge. While `in_valid` is low, the result register keeps its last value.

Top module: `masked_lzc512`

## Requirements
- R1: After reset, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: For a lane whose mask bit is 1, that lane of `result` holds the number of zero bits above the highest set bit of the input lane. The count sits in bits 6:0 of the lane, and bits 63:7 are zero.
- R4: An input lane that is entirely zero gives a count of 64.
- R5: An input lane with bit 63 set gives a count of 0.
- R6: When `merge_mode` is 0, a lane whose mask bit is 0 becomes zero.
- R7: When `merge_mode` is 1, a lane whose mask bit is 0 takes the matching lane of `pass_vec`.
- R8: While `in_valid` is 0, `result` keeps its value, whatever the other inputs do.
- R9: Lane N covers bits 64N+63 down to 64N of every vector, and only mask bit N controls it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The inputs carry a request this cycle |
| src_vec | input | 512 | Eight 64-bit lanes to count |
| pass_vec | input | 512 | Lanes copied into unselected lanes in merge mode |
| lane_mask | input | 8 | Bit N selects lane N to receive its count |
| merge_mode | input | 1 | 0: unselected lanes become zero; 1: they take `pass_vec` |
| out_valid | output | 1 | `result` was updated on the last clock edge |
| result | output | 512 | Registered per-lane counts or filler values |

## Verification
Every result is due exactly one rising edge after the cycle in which `in_valid` was high. There is a single register stage between the inputs and both `result` and `out_valid`.

The bench changes its inputs on the falling edge and reads the outputs on the next falling edge. Each sample therefore falls half a period after the edge that loaded it.

The hold checks work differently. The bench keeps `in_valid` low for several cycles while it changes every other input. It then compares `result` against the value it read before those cycles, and checks that `out_valid` dropped one edge after `in_valid` did.

// File: rtl/masked_lzc512.sv
module masked_lzc512 #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] src_vec,
  input  logic [LANES*LANE_W-1:0] pass_vec,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    merge_mode,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int CNT_W = $clog2(LANE_W) + 1;
  localparam int PAD_W = LANE_W - CNT_W;
  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] next_res;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] word;
    logic [LANE_W-1:0] filler;
    logic [CNT_W-1:0]  cnt;

    assign word   = src_vec[g*LANE_W +: LANE_W];
    assign filler = merge_mode ? pass_vec[g*LANE_W +: LANE_W] : '0;

    always_comb begin
      logic seen;
      seen = 1'b0;
      cnt  = '0;
      for (int b = LANE_W - 1; b >= 0; b--) begin
        if (!seen) begin
          if (word[b]) seen = 1'b1;
          else         cnt  = cnt + 1'b1;
        end
      end
    end

    assign next_res[g*LANE_W +: LANE_W] = lane_mask[g] ? {{PAD_W{1'b0}}, cnt} : filler;

    assert_count_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_mask[g]) |=> (result[g*LANE_W+CNT_W +: PAD_W] == '0));

    assert_count_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_mask[g]) |=> (result[g*LANE_W +: LANE_W] <= LANE_W));

    assert_msb_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_mask[g] && src_vec[g*LANE_W+LANE_W-1]) |=>
        (result[g*LANE_W +: LANE_W] == '0));

    assert_zeroing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_mask[g] && !merge_mode) |=> (result[g*LANE_W +: LANE_W] == '0));

    assert_merging_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_mask[g] && merge_mode) |=>
        (result[g*LANE_W +: LANE_W] == $past(pass_vec[g*LANE_W +: LANE_W])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_R1: assert (!out_valid && result == '0);
  end
endmodule

// File: tb/test_masked_lzc512.sv
module test_masked_lzc512;
  localparam int PERIOD = 10;
  localparam int NT = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src_vec = '0;
  logic [511:0] pass_vec = '0;
  logic [7:0]   lane_mask = '0;
  logic         merge_mode = 1'b0;
  logic         out_valid;
  logic [511:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  masked_lzc512 i_masked_lzc512 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .pass_vec(pass_vec), .lane_mask(lane_mask), .merge_mode(merge_mode),
    .out_valid(out_valid), .result(result)
  );

  localparam logic [63:0] T_SEED [NT] = '{64'h8000_0000_0000_0001, 64'h0123_4567_89ab_cdef,
    64'h0000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 64'h0000_0400_0000_0000, 64'h5a5a_0000_0000_00f0};
  localparam logic [63:0] T_PASS [NT] = '{64'hdead_beef_0000_1111, 64'h1111_2222_3333_4444,
    64'hcafe_f00d_cafe_f00d, 64'h0, 64'h7777_0000_7777_0000, 64'hffff_ffff_ffff_fff0};
  localparam logic [7:0] T_MASK [NT] = '{8'hff, 8'h5a, 8'h0f, 8'h00, 8'ha5, 8'h81};
  localparam logic       T_MODE [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  function automatic logic [63:0] ref_lz(input logic [63:0] x);
    logic [63:0] c;
    c = 64;
    for (int i = 0; i < 64; i++) if (x[i]) c = 64'(63 - i);
    return c;
  endfunction

  function automatic logic [511:0] model(input logic [511:0] s, input logic [511:0] p,
                                         input logic [7:0] m, input logic md);
    logic [511:0] r;
    for (int n = 0; n < 8; n++) begin
      if (m[n])    r[n*64 +: 64] = ref_lz(s[n*64 +: 64]);
      else if (md) r[n*64 +: 64] = p[n*64 +: 64];
      else         r[n*64 +: 64] = '0;
    end
    return r;
  endfunction

  function automatic logic [511:0] spread(input logic [63:0] seed, input bit xorlane);
    logic [511:0] v;
    for (int n = 0; n < 8; n++)
      v[n*64 +: 64] = xorlane ? (seed ^ 64'(n)) : (seed >> (n*7));
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [511:0] s, input logic [511:0] p, input logic [7:0] m, input logic md);
    @(negedge clk);
    src_vec = s; pass_vec = p; lane_mask = m; merge_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] s, p, held;
    repeat (3) @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_vec("R1 result after reset", result, '0);
    rst_n = 1'b1;

    for (int t = 0; t < NT; t++) begin
      s = spread(T_SEED[t], 1'b0);
      p = spread(T_PASS[t], 1'b1);
      issue(s, p, T_MASK[t], T_MODE[t]);
      check_bit("R2 out_valid one edge after in_valid", out_valid, 1'b1);
      check_vec(T_MODE[t] ? "R3/R7 table merge entry" : "R3/R6 table zeroing entry",
                result, model(s, p, T_MASK[t], T_MODE[t]));
    end

    issue('0, '1, 8'hff, 1'b0);
    check_vec("R4 all-zero lanes give 64", result, {8{64'd64}});

    s = {8{64'h8000_0000_0000_0000}} | spread(64'h0123_0000_0000_0000, 1'b0);
    issue(s, '0, 8'hff, 1'b1);
    check_vec("R5 msb set gives 0", result, '0);

    s = spread(64'h0000_0001_0000_0000, 1'b0);
    p = spread(64'haaaa_0000_0000_0000, 1'b1);
    issue(s, p, 8'h00, 1'b0);
    check_vec("R6 all lanes zeroed", result, '0);
    issue(s, p, 8'h00, 1'b1);
    check_vec("R7 all lanes merged", result, p);

    s = '0;
    s[63:0]    = 64'h0000_0000_0000_0100;
    s[511:448] = 64'h0000_0000_0000_0001;
    p = spread(64'h1234_0000_0000_5678, 1'b1);
    issue(s, p, 8'h01, 1'b1);
    check_vec("R9 lane0 bits 63:0 under mask bit 0",
              result, {p[511:64], 64'd55});
    issue(s, p, 8'h80, 1'b0);
    check_vec("R9 lane7 bits 511:448 under mask bit 7",
              result, {64'd63, 448'd0});

    held = result;
    @(negedge clk);
    check_bit("R2 out_valid drops", out_valid, 1'b0);
    src_vec = '1; pass_vec = '1; lane_mask = 8'hff; merge_mode = 1'b1;
    repeat (3) begin
      @(negedge clk);
      lane_mask = ~lane_mask;
    end
    check_vec("R8 result held while idle", result, held);
    check_bit("R8 out_valid low while idle", out_valid, 1'b0);

    rst_n = 1'b0;
    @(negedge clk);
    check_vec("R1 result cleared by reset", result, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule